// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block paces auto-refresh for an SDRAM controller. Software writes an 8-bit control byte whose low two bits choose the refresh period: off, 7.8 µs, 15.6 µs or 125 µs. The memory clock runs at the processor bus rate, which is one of three frequencies. A 2-bit frequency input tells the block which one, so that each period becomes the correct number of clock cycles.

When a period runs out, the block raises a request. The request stays up until the controller returns an acknowledge, and the next period starts counting from that acknowledge. While one request is still waiting, later expiries are not queued. Writing the control byte restarts the current count at once. Writing the off code also withdraws any waiting request.

Top module: `refresh_tick`

## Requirements
- R1: After reset, `refReq` is low. No request is raised until the rate field has been written with a nonzero code.
- R2: Rate code 2'b00 disables refresh, so `refReq` never rises. Writing 2'b00 clears a waiting request, and `refReq` is low one cycle after the write edge.
- R3: With `freqSel` = 2'b00 (66.67 MHz), rate codes 2'b01, 2'b10 and 2'b11 give periods of 520, 1040 and 8333 cycles.
- R4: With `freqSel` = 2'b01 (100 MHz), the periods are 780, 1560 and 12500 cycles. With `freqSel` = 2'b10 or 2'b11 (133.33 MHz), they are 1040, 2080 and 16667 cycles.
- R5: `refReq` rises exactly N cycles after a load edge. A load edge is a clock edge on which `cfgWe` is high, or on which `refAck` is high while `refReq` is high. N is the period for the rate and `freqSel` in force at that load.
- R6: Once raised, `refReq` stays high until an acknowledge arrives (or a 2'b00 write). It is low in the cycle after the edge where `refAck` was sampled high.
- R7: The acknowledge edge starts the next period, and the next request rises N cycles after it.
- R8: At most one request is pending. Expiries while `refReq` is high are dropped, so after a single acknowledge `refReq` is low and the next request comes a full N cycles later.
- R9: A write with a nonzero code reloads the count immediately, using the new code. A request that is already pending stays high.
- R10: The rate field is bits 1:0 of `cfgData`. Bits 7:2 are ignored.
- R11: `freqSel` is used when a period is loaded. Changing it while a period is running does not alter that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Write strobe for the control byte |
| cfgData | input | 8 | Control byte; bits 1:0 hold the rate code |
| freqSel | input | 2 | Bus clock: 00 = 66.67 MHz, 01 = 100 MHz, 10/11 = 133.33 MHz |
| refAck | input | 1 | Controller acknowledge of the pending request |
| refReq | output | 1 | Refresh request, held until acknowledged |

## Verification
A wrong down-counter value or a wrong reload entry shows up only at the next rising edge of `refReq`. That edge comes early or late compared with the load that started the period, so it can stay hidden for up to 16667 cycles. Every rise is therefore timed against the last write or accepted acknowledge. A wrong pending flag shows up as soon as the next edge: the request drops without an acknowledge, survives one, or comes back too soon after it. For that reason the request level is checked right after each acknowledge and after each write of the off code.

// File: rtl/refresh_tick_pkg.sv
package refresh_tick_pkg;

  localparam int unsigned PERIOD_NS_A = 7800;
  localparam int unsigned PERIOD_NS_B = 15600;
  localparam int unsigned PERIOD_NS_C = 125000;
  localparam int unsigned BUS_KHZ_LO  = 66667;
  localparam int unsigned BUS_KHZ_MID = 100000;
  localparam int unsigned BUS_KHZ_HI  = 133333;

  typedef struct packed {
    logic       load;
    logic [1:0] loadRate;
    logic       run;
  } tickCtrl_t;

  function automatic int unsigned periodCycles(input logic [1:0] rate, input logic [1:0] freq);
    longint unsigned ns;
    longint unsigned khz;
    case (rate)
      2'b01:   ns = PERIOD_NS_A;
      2'b10:   ns = PERIOD_NS_B;
      2'b11:   ns = PERIOD_NS_C;
      default: ns = 0;
    endcase
    case (freq)
      2'b00:   khz = BUS_KHZ_LO;
      2'b01:   khz = BUS_KHZ_MID;
      default: khz = BUS_KHZ_HI;
    endcase
    return int'((ns * khz + 64'd500000) / 64'd1000000);
  endfunction

endpackage

// File: rtl/refresh_tick_dp.sv
module refresh_tick_dp
  import refresh_tick_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic      clk,
  input  logic      rst_n,
  input  tickCtrl_t ctrl,
  input  logic [1:0] freqSel,
  input  logic [1:0] curRate,
  output logic      expire
);
  localparam int RATES = 4;
  localparam int FREQS = 4;

  logic [CNT_W-1:0] reloadTbl [RATES][FREQS];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] runVal;

  for (genvar r = 0; r < RATES; r++) begin : g_rate
    for (genvar f = 0; f < FREQS; f++) begin : g_freq
      localparam int unsigned CYC = periodCycles(r[1:0], f[1:0]);
      assign reloadTbl[r][f] = (CYC == 0) ? '0 : CNT_W'(CYC - 1);
    end
  end

  assign loadVal = reloadTbl[ctrl.loadRate][freqSel];
  assign runVal  = reloadTbl[curRate][freqSel];
  assign expire  = ctrl.run && !ctrl.load && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ctrl.load) begin
      cnt <= loadVal;
    end else if (ctrl.run) begin
      cnt <= (cnt == '0) ? runVal : cnt - 1'b1;
    end
  end

endmodule

// File: rtl/refresh_tick_ctl.sv
module refresh_tick_ctl
  import refresh_tick_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWe,
  input  logic [1:0] newRate,
  input  logic       refAck,
  input  logic       expire,
  output tickCtrl_t  ctrl,
  output logic [1:0] curRate,
  output logic       refReq
);
  logic [1:0] rateQ;
  logic       reqQ;
  logic       ackTaken;

  assign ackTaken      = refAck && reqQ;
  assign ctrl.load     = cfgWe || ackTaken;
  assign ctrl.loadRate = cfgWe ? newRate : rateQ;
  assign ctrl.run      = (rateQ != 2'b00);
  assign curRate       = rateQ;
  assign refReq        = reqQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rateQ <= 2'b00;
      reqQ  <= 1'b0;
    end else begin
      if (cfgWe) rateQ <= newRate;
      if (cfgWe && newRate == 2'b00) reqQ <= 1'b0;
      else if (ackTaken)             reqQ <= 1'b0;
      else if (expire)               reqQ <= 1'b1;
    end
  end

endmodule

// File: rtl/refresh_tick.sv
module refresh_tick
  import refresh_tick_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWe,
  input  logic [7:0] cfgData,
  input  logic [1:0] freqSel,
  input  logic       refAck,
  output logic       refReq
);
  tickCtrl_t  ctrl;
  logic [1:0] curRate;
  logic       expire;
  logic       unusedCfgHi;

  assign unusedCfgHi = ^cfgData[7:2];

  refresh_tick_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfgWe   (cfgWe),
    .newRate (cfgData[1:0]),
    .refAck  (refAck),
    .expire  (expire),
    .ctrl    (ctrl),
    .curRate (curRate),
    .refReq  (refReq)
  );

  refresh_tick_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .freqSel (freqSel),
    .curRate (curRate),
    .expire  (expire)
  );

endmodule

// File: rtl/refresh_tick_chk.sv
module refresh_tick_chk
  import refresh_tick_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfgWe,
  input logic [7:0] cfgData,
  input logic [1:0] freqSel,
  input logic       refAck,
  input logic       refReq
);
  logic [1:0]  rateSeen;
  logic [31:0] sinceLoad;
  logic [31:0] expN;
  logic        loadEv;

  assign loadEv = cfgWe || (refAck && refReq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rateSeen  <= 2'b00;
      sinceLoad <= '0;
      expN      <= '0;
    end else begin
      if (cfgWe) rateSeen <= cfgData[1:0];
      if (loadEv) begin
        sinceLoad <= '0;
        expN      <= periodCycles(cfgWe ? cfgData[1:0] : rateSeen, freqSel);
      end else if (sinceLoad != 32'hFFFF_FFFF) begin
        sinceLoad <= sinceLoad + 1;
      end
    end
  end

  p_off_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWe && cfgData[1:0] == 2'b00) |=> !refReq);

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rateSeen == 2'b00 && !cfgWe) |=> !refReq);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (refReq && !refAck && !(cfgWe && cfgData[1:0] == 2'b00)) |=> refReq);

  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (refReq && refAck) |=> !refReq);

  p_interval_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refReq) |-> (sinceLoad == expN));

endmodule

bind refresh_tick refresh_tick_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfgWe   (cfgWe),
  .cfgData (cfgData),
  .freqSel (freqSel),
  .refAck  (refAck),
  .refReq  (refReq)
);

// File: tb/sim_refresh_tick.sv
module sim_refresh_tick;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgData = 8'h00;
  logic [1:0] freqSel = 2'b00;
  logic       refAck = 1'b0;
  logic       refReq;

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  refresh_tick u0 (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgData(cfgData),
    .freqSel(freqSel), .refAck(refAck), .refReq(refReq)
  );

  function automatic int expCycles(input int rate, input int freq);
    int t [3][3] = '{'{520, 1040, 8333}, '{780, 1560, 12500}, '{1040, 2080, 16667}};
    int fi = (freq > 2) ? 2 : freq;
    return t[fi][rate-1];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgData = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic doAck();
    @(negedge clk); refAck = 1'b1;
    @(negedge clk); refAck = 1'b0;
  endtask

  task automatic waitReq(input int start, output int k);
    k = start;
    while (!refReq && k < 20000) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic quietFor(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (refReq) seen = 1'b1;
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  task automatic t_reset();
    check(refReq == 1'b0, "R1 reset", int'(refReq), 0);
    quietFor(300, "R1 no request before write");
  endtask

  task automatic t_table();
    int k;
    for (int f = 0; f < 4; f++) begin
      for (int r = 1; r < 4; r++) begin
        if (f == 3 && r > 1) continue;
        if (refReq) doAck();
        @(negedge clk); freqSel = 2'(f);
        doWrite(8'(r));
        waitReq(0, k);
        check(k == expCycles(r, f), (f == 0) ? "R3 period" : "R4 period R5", k, expCycles(r, f));
      end
    end
  endtask

  task automatic t_ack();
    int k;
    if (refReq) doAck();
    @(negedge clk); freqSel = 2'b01;
    doWrite(8'h01);
    waitReq(0, k);
    check(k == 780, "R5 first rise", k, 780);
    repeat (50) @(negedge clk);
    check(refReq == 1'b1, "R6 held", int'(refReq), 1);
    doAck();
    check(refReq == 1'b0, "R6 cleared by ack", int'(refReq), 0);
    waitReq(0, k);
    check(k == 780, "R7 restart at ack", k, 780);
  endtask

  task automatic t_single_pending();
    int k;
    repeat (3 * 780 + 10) @(negedge clk);
    check(refReq == 1'b1, "R8 still pending", int'(refReq), 1);
    doAck();
    check(refReq == 1'b0, "R8 one ack clears", int'(refReq), 0);
    waitReq(0, k);
    check(k == 780, "R8 full period after ack", k, 780);
  endtask

  task automatic t_off_and_field();
    int k;
    doWrite(8'h00);
    check(refReq == 1'b0, "R2 off clears pending", int'(refReq), 0);
    quietFor(2000, "R2 off stays quiet");
    doWrite(8'hFC);
    quietFor(1000, "R10 upper bits ignored on off");
    doWrite(8'hFD);
    waitReq(0, k);
    check(k == 780, "R10 upper bits ignored", k, 780);
  endtask

  task automatic t_rewrite();
    int k;
    doAck();
    doWrite(8'h02);
    repeat (500) @(negedge clk);
    check(refReq == 1'b0, "R9 before rewrite", int'(refReq), 0);
    doWrite(8'h01);
    waitReq(0, k);
    check(k == 780, "R9 reload on write", k, 780);
    doWrite(8'h03);
    check(refReq == 1'b1, "R9 pending kept", int'(refReq), 1);
  endtask

  task automatic t_freq_change();
    int k;
    doAck();
    @(negedge clk); freqSel = 2'b00;
    doWrite(8'h01);
    repeat (100) @(negedge clk);
    freqSel = 2'b10;
    waitReq(100, k);
    check(k == 520, "R11 freq sampled at load", k, 520);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_table();
    t_ack();
    t_single_pending();
    t_off_and_field();
    t_rewrite();
    t_freq_change();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule